// File: doc/BRIEF.md
# SPI Command Engine with Register Bank

This block is a host-side SPI master that a processor drives through eight byte-wide registers. Software first writes the opcode and any address or data bytes into fixed registers. It then writes a control byte that gives the number of bytes to send, the number of bytes to receive and the clock speed. The engine asserts chip select and shifts the selected bytes out MSB first. It then clocks in up to three response bytes, places them in the receive registers and releases chip select. A busy flag in the control register lets software poll for completion.

Only four send lengths exist: 1, 2, 4 and 5 bytes, chosen by a 2-bit code. The three address bytes of 4- and 5-byte commands are taken from the registers in descending offset order. The SPI clock is the system clock divided by one of two half-period counts, and the bus runs in mode 0.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, csN is 1, sck is 0, mosi is 0, and all eight offsets read 0x00.
- R2: A write to offset 0 whose bits 7:4 equal 0x4 or 0x5, made while idle, starts a frame. Offset 0 then reads with bit 7 = 1 from the next clock until the frame ends, and bits 6:0 hold bits 6:0 of the accepted control byte.
- R3: Control bits 1:0 choose the send sequence, each byte MSB first: code 0 sends offset 1; code 1 sends offsets 1, 7; code 2 sends offsets 1, 4, 3, 2; code 3 sends offsets 1, 4, 3, 2, 7.
- R4: Control bits 3:2 give a receive count of 0 to 3. The received bytes follow the sent bytes, mosi is 0 while they are clocked, and they are stored at offsets 5, 6 and 7 in arrival order. Receive offsets beyond the count keep their values.
- R5: The bus runs in mode 0. sck is 0 whenever csN is 1, miso is sampled on sck rising edges, and mosi does not change while sck is high.
- R6: csN goes low exactly once per frame and stays low from the start of the first sent byte to the end of the last received byte.
- R7: Let N be the number of sent plus received bytes. A frame keeps the busy bit set for (16·N + 2)·H clocks. H is SLOW_HALF when control bit 4 is 0 and FAST_HALF when it is 1.
- R8: While busy, writes to any offset are ignored. A control write does not restart or extend the frame, and data registers keep their values.
- R9: A control write made while idle, whose bits 7:4 are neither 0x4 nor 0x5, is ignored. No frame starts and the offset 0 readback does not change.
- R10: While idle, a write to offsets 1 to 7 is stored and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| sck | output | 1 | SPI serial clock |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The busy bit is due on the clock after the control write. The bench samples it at every falling edge after that write and compares the number of busy samples with (16·N + 2)·H. Sent bytes are checked as they complete, on the eighth sck rise of each byte, against a queue that the driver fills before the frame starts. Receive registers, the control readback and the count of chip-select pulses are read on the first falling edge after busy has cleared. Writes made during busy are placed at fixed busy-sample counts, so they land in the middle of the frame.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int BYTE_W    = 8;
  localparam int NUM_REGS  = 8;
  localparam int OFS_W     = $clog2(NUM_REGS);
  localparam int BCNT_W    = 4;
  localparam logic [OFS_W-1:0] RX_OFS = OFS_W'(5);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_TRAIL} phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             loadZero;
    logic [OFS_W-1:0] loadSel;
    logic             shift;
    logic             sample;
    logic             store;
    logic [OFS_W-1:0] storeSel;
  } dpStrobe_t;

  function automatic logic [BCNT_W-1:0] wrLenOf(input logic [1:0] code);
    case (code)
      2'd0:    return BCNT_W'(1);
      2'd1:    return BCNT_W'(2);
      2'd2:    return BCNT_W'(4);
      default: return BCNT_W'(5);
    endcase
  endfunction

  // Register offset of send byte idx; the address bytes go out highest offset first
  function automatic logic [OFS_W-1:0] txOffset(input logic [1:0] code,
                                                input logic [BCNT_W-1:0] idx);
    logic [OFS_W-1:0] ofs;
    if (idx == '0)                 ofs = OFS_W'(1);
    else if (code == 2'd1)         ofs = OFS_W'(7);
    else if (idx == BCNT_W'(4))    ofs = OFS_W'(7);
    else                           ofs = OFS_W'(BCNT_W'(5) - idx);
    return ofs;
  endfunction

endpackage

// File: rtl/spi_cmd_dpath.sv
module spi_cmd_dpath
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic [OFS_W-1:0]  regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic              busy,
  input  dpStrobe_t         strb,
  input  logic              miso,
  output logic              mosi,
  output logic              startGo,
  output logic [1:0]        startCode,
  output logic [1:0]        startRd,
  output logic              startFast
);

  logic [BYTE_W-2:0] ctrlR;
  logic [BYTE_W-1:0] regQ [NUM_REGS];
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rxShift;
  logic              ctrlHit;
  logic              ctrlValid;

  assign ctrlHit   = regWe && !busy && (regAddr == '0);
  assign ctrlValid = (regWrData[7:4] == 4'h4) || (regWrData[7:4] == 4'h5);
  assign startGo   = ctrlHit && ctrlValid;
  assign startCode = regWrData[1:0];
  assign startRd   = regWrData[3:2];
  assign startFast = regWrData[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrlR <= '0;
    else if (startGo) ctrlR <= regWrData[BYTE_W-2:0];
  end

  assign regQ[0] = {busy, ctrlR};

  // Data registers 1..7: receive store wins, host writes only while idle
  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regQ[g] <= '0;
      else if (strb.store && (strb.storeSel == OFS_W'(g)))
        regQ[g] <= rxShift;
      else if (regWe && !busy && (regAddr == OFS_W'(g)))
        regQ[g] <= regWrData;
    end
  end

  assign regRdData = regQ[regAddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            txShift <= '0;
    else if (strb.load)    txShift <= strb.loadZero ? '0 : regQ[strb.loadSel];
    else if (strb.shift)   txShift <= {txShift[BYTE_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rxShift <= '0;
    else if (strb.sample)  rxShift <= {rxShift[BYTE_W-2:0], miso};
  end

  assign mosi = busy & txShift[BYTE_W-1];

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int SLOW_HALF = 4,
  parameter int FAST_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startGo,
  input  logic [1:0] startCode,
  input  logic [1:0] startRd,
  input  logic       startFast,
  output logic       busy,
  output logic       sck,
  output logic       csN,
  output dpStrobe_t  strb
);

  localparam int MAX_HALF = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int DIV_W    = $clog2(MAX_HALF + 1);
  localparam logic [DIV_W-1:0] SLOW_LIM = DIV_W'(SLOW_HALF - 1);
  localparam logic [DIV_W-1:0] FAST_LIM = DIV_W'(FAST_HALF - 1);

  phase_t            state;
  logic [DIV_W-1:0]  divCnt;
  logic              fastR;
  logic [1:0]        codeR;
  logic [1:0]        rdR;
  logic [BCNT_W-1:0] byteIdx;
  logic [2:0]        bitIdx;
  logic              sckR;

  logic              halfTick;
  logic              lastBit;
  logic [BCNT_W-1:0] wrLen;
  logic [BCNT_W-1:0] totalBytes;
  logic [BCNT_W-1:0] nextIdx;

  assign wrLen      = wrLenOf(codeR);
  assign totalBytes = wrLen + BCNT_W'(rdR);
  assign nextIdx    = byteIdx + BCNT_W'(1);
  assign lastBit    = (bitIdx == 3'd7);
  assign halfTick   = (state != ST_IDLE) &&
                      (divCnt == (fastR ? FAST_LIM : SLOW_LIM));

  always_comb begin
    strb = '0;
    if (state == ST_IDLE && startGo) begin
      strb.load    = 1'b1;
      strb.loadSel = txOffset(startCode, '0);
    end
    if (state == ST_XFER && halfTick) begin
      if (!sckR) begin
        strb.sample = 1'b1;
      end else if (!lastBit) begin
        strb.shift = 1'b1;
      end else begin
        if (byteIdx >= wrLen) begin
          strb.store    = 1'b1;
          strb.storeSel = RX_OFS + OFS_W'(byteIdx - wrLen);
        end
        if (nextIdx < totalBytes) begin
          strb.load = 1'b1;
          if (nextIdx < wrLen) strb.loadSel  = txOffset(codeR, nextIdx);
          else                 strb.loadZero = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      fastR   <= 1'b0;
      codeR   <= '0;
      rdR     <= '0;
      byteIdx <= '0;
      bitIdx  <= '0;
      sckR    <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (startGo) begin
        state   <= ST_LEAD;
        fastR   <= startFast;
        codeR   <= startCode;
        rdR     <= startRd;
        divCnt  <= '0;
        byteIdx <= '0;
        bitIdx  <= '0;
        sckR    <= 1'b0;
      end
    end else begin
      divCnt <= halfTick ? '0 : divCnt + DIV_W'(1);
      case (state)
        ST_LEAD: if (halfTick) state <= ST_XFER;
        ST_XFER: begin
          if (halfTick) begin
            sckR <= !sckR;
            if (sckR) begin
              if (lastBit) begin
                bitIdx <= '0;
                if (nextIdx == totalBytes) state <= ST_TRAIL;
                else                       byteIdx <= nextIdx;
              end else begin
                bitIdx <= bitIdx + 3'd1;
              end
            end
          end
        end
        ST_TRAIL: if (halfTick) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign csN  = (state == ST_IDLE);
  assign sck  = sckR;

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int SLOW_HALF = 4,
  parameter int FAST_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       regWe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       sck,
  output logic       csN,
  output logic       mosi,
  input  logic       miso
);

  dpStrobe_t  strb;
  logic       busy;
  logic       startGo;
  logic [1:0] startCode;
  logic [1:0] startRd;
  logic       startFast;

  spi_cmd_ctrl #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startGo   (startGo),
    .startCode (startCode),
    .startRd   (startRd),
    .startFast (startFast),
    .busy      (busy),
    .sck       (sck),
    .csN       (csN),
    .strb      (strb)
  );

  spi_cmd_dpath u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .busy      (busy),
    .strb      (strb),
    .miso      (miso),
    .mosi      (mosi),
    .startGo   (startGo),
    .startCode (startCode),
    .startRd   (startRd),
    .startFast (startFast)
  );

endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       regWe,
  input logic [2:0] regAddr,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       sck,
  input logic       csN,
  input logic       mosi
);

  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    csN |-> !sck);

  assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!csN && sck && $past(sck)) |-> $stable(mosi));

  assert_start_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csN) |-> $past(regWe && (regAddr == 3'd0) &&
                         ((regWrData[7:4] == 4'h4) || (regWrData[7:4] == 4'h5))));

  assert_busy_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == 3'd0) |-> (regRdData[7] == !csN));

  assert_mosi_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    csN |-> !mosi);

endmodule

bind spi_cmd_engine spi_cmd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .regWe     (regWe),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .sck       (sck),
  .csN       (csN),
  .mosi      (mosi)
);

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;

  localparam int SLOW_H = 4;
  localparam int FAST_H = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWe = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       sck, csN, mosi;
  logic       miso = 1'b0;

  int  checkCnt = 0;
  int  failCnt  = 0;
  bit  done     = 1'b0;

  logic [7:0] expQ[$];
  logic [7:0] txRegs [8];
  logic [7:0] respRx [3];
  logic [7:0] slvResp [8];
  int         slvBit  = 0;
  int         capBits = 0;
  logic [7:0] capByte = 8'h00;
  int         csFalls = 0;

  spi_cmd_engine #(.SLOW_HALF(SLOW_H), .FAST_HALF(FAST_H)) u_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .sck(sck), .csN(csN), .mosi(mosi), .miso(miso)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  // Device model: presents bit k of the response stream, updated on sck falls
  always @(negedge csN) begin
    slvBit = 0;
    miso   = slvResp[0][7];
    csFalls++;
    capBits = 0;
  end

  always @(negedge sck) begin
    if (!csN) begin
      slvBit++;
      if (slvBit < 64) miso = slvResp[slvBit / 8][7 - (slvBit % 8)];
    end
  end

  // Monitor: rebuild each byte from mosi at sck rises and compare with the queue
  always @(posedge sck) begin
    if (!csN) begin
      capByte = {capByte[6:0], mosi};
      capBits++;
      if (capBits == 8) begin
        capBits = 0;
        if (expQ.size() == 0) begin
          chk(1'b0, "R3 unexpected mosi byte", capByte, 0);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          chk(capByte == e, "R3/R4 mosi byte", capByte, e);
        end
      end
    end
  end

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWe = 1'b0; regAddr = 3'd0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic runFrame(input logic [1:0] code, input logic [1:0] rd,
                          input bit fast, input bit mid);
    int wl, n, cnt, h;
    logic [7:0] ctrlByte, v, e;
    int csBefore;
    for (int i = 1; i < 8; i++) wrReg(3'(i), txRegs[i]);
    wl = (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 4 : 5;
    n  = wl + int'(rd);
    h  = fast ? FAST_H : SLOW_H;
    expQ.push_back(txRegs[1]);
    if (code == 2'd1) expQ.push_back(txRegs[7]);
    if (code >= 2'd2) begin
      expQ.push_back(txRegs[4]);
      expQ.push_back(txRegs[3]);
      expQ.push_back(txRegs[2]);
    end
    if (code == 2'd3) expQ.push_back(txRegs[7]);
    for (int j = 0; j < int'(rd); j++) expQ.push_back(8'h00);
    for (int i = 0; i < 8; i++)
      slvResp[i] = (i < wl) ? 8'hC3 : (i < n) ? respRx[i - wl] : 8'h00;
    csBefore = csFalls;
    ctrlByte = {3'b010, fast, rd, code};
    wrReg(3'd0, ctrlByte);
    cnt = 0;
    forever begin
      regWe = 1'b0; regAddr = 3'd0;
      #1;
      if (!regRdData[7] || cnt > 5000) break;
      cnt++;
      if (mid && cnt == 10) begin regWe = 1'b1; regAddr = 3'd0; regWrData = 8'h5B; end
      if (mid && cnt == 20) begin regWe = 1'b1; regAddr = 3'd2; regWrData = 8'hAA; end
      @(negedge clk);
    end
    regWe = 1'b0;
    chk(cnt == (16 * n + 2) * h, "R7 busy length", cnt, (16 * n + 2) * h);
    chk(expQ.size() == 0, "R3 bytes left unsent", expQ.size(), 0);
    expQ.delete();
    chk(csFalls == csBefore + 1, "R6 csN pulses", csFalls - csBefore, 1);
    rdReg(3'd0, v);
    chk(v == {1'b0, ctrlByte[6:0]}, "R2 control readback", v, {1'b0, ctrlByte[6:0]});
    for (int j = 0; j < 3; j++) begin
      e = (j < int'(rd)) ? respRx[j] : txRegs[5 + j];
      rdReg(3'(5 + j), v);
      chk(v == e, "R4 receive register", v, e);
    end
    if (mid) begin
      rdReg(3'd2, v);
      chk(v == txRegs[2], "R8 data write while busy", v, txRegs[2]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 8; i++) slvResp[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(csN == 1'b1, "R1 csN", csN, 1);
    chk(sck == 1'b0, "R1 sck", sck, 0);
    chk(mosi == 1'b0, "R1 mosi", mosi, 0);
    for (int i = 0; i < 8; i++) begin
      rdReg(3'(i), v);
      chk(v == 8'h00, "R1 register reset", v, 0);
    end

    // R9: control writes with an invalid upper nibble start nothing
    wrReg(3'd0, 8'h2D);
    wrReg(3'd0, 8'h6F);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(csN == 1'b1, "R9 no frame", csN, 1);
    end
    rdReg(3'd0, v);
    chk(v == 8'h00, "R9 control unchanged", v, 0);

    // R10: data register readback
    for (int i = 1; i < 8; i++) wrReg(3'(i), 8'(8'h11 * i));
    for (int i = 1; i < 8; i++) begin
      rdReg(3'(i), v);
      chk(v == 8'(8'h11 * i), "R10 register readback", v, 8'(8'h11 * i));
    end

    // Frames covering every send code, receive counts and both speeds
    txRegs = '{8'h00, 8'h06, 8'h21, 8'h22, 8'h23, 8'hA5, 8'hA6, 8'hA7};
    respRx = '{8'h00, 8'h00, 8'h00};
    runFrame(2'd0, 2'd0, 1'b0, 1'b0);

    txRegs = '{8'h00, 8'h9F, 8'h01, 8'h02, 8'h03, 8'h11, 8'h12, 8'h13};
    respRx = '{8'hEF, 8'h40, 8'h16};
    runFrame(2'd0, 2'd3, 1'b1, 1'b0);

    txRegs = '{8'h00, 8'h01, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h3C};
    respRx = '{8'h00, 8'h00, 8'h00};
    runFrame(2'd1, 2'd0, 1'b0, 1'b0);

    txRegs = '{8'h00, 8'h20, 8'h56, 8'h34, 8'h12, 8'hB1, 8'hB2, 8'hB3};
    respRx = '{8'h5A, 8'h00, 8'h00};
    runFrame(2'd2, 2'd1, 1'b1, 1'b0);

    // R8: writes during the frame are ignored
    txRegs = '{8'h00, 8'h02, 8'h0F, 8'h1E, 8'h2D, 8'hC1, 8'hC2, 8'h99};
    respRx = '{8'h00, 8'h00, 8'h00};
    runFrame(2'd3, 2'd0, 1'b0, 1'b1);

    txRegs = '{8'h00, 8'h03, 8'h80, 8'h40, 8'h01, 8'hD1, 8'hD2, 8'h7E};
    respRx = '{8'h81, 8'h42, 8'h00};
    runFrame(2'd3, 2'd2, 1'b1, 1'b0);

    txRegs = '{8'h00, 8'h0B, 8'hFE, 8'hDC, 8'hBA, 8'hE1, 8'hE2, 8'h6D};
    respRx = '{8'h3B, 8'hFF, 8'hA4};
    runFrame(2'd3, 2'd3, 1'b1, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule